// File: doc/BRIEF.md
# Region-gated read-allocate cache controller

This controller places a small direct-mapped or two-way data cache between a processor load/store port and a word-wide memory port. With every access comes a cacheable flag, produced by a region attribute lookup outside the block. Only accesses that carry the flag use the cache. All other accesses go to memory unchanged, and the cache is neither searched nor written.

A cacheable load is looked up in the tags. On a hit the cached word is returned. On a miss the whole four-word line holding the address is read from memory in ascending order, starting at the line-aligned address, and the load completes as soon as its own word arrives. The fill goes into an invalid way if the set has one. Only when both ways are valid does the line replace the least recently used way, which one LRU bit per set tracks. A cacheable store that hits updates the cached copy and also writes memory, so no dirty state is kept. A store that misses only writes memory and allocates nothing.

The processor side takes one request at a time: a request is accepted in a cycle where `cpu_valid` and `cpu_ready` are both high, and `cpu_done` pulses once for it. The memory side holds `mem_req` and its address, data and direction until `mem_ack` pulses.

Top module: `rgc_cache`

## Requirements
- R1: Reset clears every valid bit, so the first cacheable load to any address after reset misses and reads four words from memory; during reset cpu_ready is 1 and mem_req and cpu_done are 0.
- R2: A cacheable load that hits returns the cached word with cpu_done high in the cycle after the lookup cycle (one clock after acceptance), and makes no memory request.
- R3: A cacheable load miss issues exactly four memory reads at addresses line_base, line_base+1, line_base+2 and line_base+3, where line_base is the address with its two low bits cleared. cpu_done and the word arrive in the cycle after the read of the requested offset is acknowledged, and cpu_ready stays low until the fourth read is acknowledged.
- R4: A miss fills an invalid way in preference to evicting a valid one, so two lines whose addresses share a set index are both resident after two misses. A given address is never resident in both ways.
- R5: When both ways of the set are valid, a miss evicts the way not used most recently, where both hits and fills count as use.
- R6: A cacheable store hit writes the new word into the cache and also performs one memory write of that address and data (write-through).
- R7: A cacheable store miss performs one memory write and no memory read, and allocates no line, so a later load of that address misses.
- R8: A non-cacheable load performs a single memory read, returns the memory word even when the address is cached, and leaves the cached copy unchanged.
- R9: A non-cacheable store performs one memory write and leaves any cached copy of that address unchanged.
- R10: While mem_req is high and mem_ack is low, mem_addr, mem_write and mem_wdata hold their values. cpu_ready is low from the cycle after acceptance for as long as the memory port is busy.
- R11: Each accepted request produces exactly one single-cycle cpu_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request present; accepted when cpu_ready is high |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_write | input | 1 | 1 for a store, 0 for a load |
| cpu_cacheable | input | 1 | Region cacheable flag for this access |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| mem_req | output | 1 | Memory transfer requested |
| mem_write | output | 1 | 1 for a memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current transfer |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |

## Verification
The bench builds the controller with four sets, two ways and a 10-bit word address, behind a memory model of 1024 words that acknowledges each transfer two cycles after the request. With only four sets, three tags land in set 0 within a few accesses. That makes it quick to show an invalid way being preferred, LRU eviction after hits and after fills, and a critical word in the middle of a line. The small address space lets the model hold every word, so memory-side effects of write-through, write-around and bypass traffic can be read back through non-cacheable loads.

// File: rtl/rgc_cache.sv
module rgc_cache #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic              cpu_cacheable,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FILL, S_MRD, S_MWR} st_t;

  st_t               st;
  logic              r_we, r_c, fill_way;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, rdata_q;
  logic [OFF_W-1:0]  cnt;
  logic              done_q;

  logic [DATA_W-1:0] dat  [2][SETS][LINE_WORDS];
  logic [TAG_W-1:0]  tags [2][SETS];
  logic [SETS-1:0]   vld  [2];
  logic [SETS-1:0]   lru;

  logic [TAG_W-1:0] r_tag;
  logic [IDX_W-1:0] r_idx;
  logic [OFF_W-1:0] r_off;
  logic hit0, hit1, hit, hit_way, victim, fill_last;

  assign r_tag = r_addr[ADDR_W-1 -: TAG_W];
  assign r_idx = r_addr[OFF_W +: IDX_W];
  assign r_off = r_addr[OFF_W-1:0];

  assign hit0    = vld[0][r_idx] && (tags[0][r_idx] == r_tag);
  assign hit1    = (WAYS > 1) && vld[1][r_idx] && (tags[1][r_idx] == r_tag);
  assign hit     = hit0 || hit1;
  assign hit_way = hit1;

  always_comb begin
    if (!vld[0][r_idx])                 victim = 1'b0;
    else if (WAYS < 2)                  victim = 1'b0;
    else if (!vld[1][r_idx])            victim = 1'b1;
    else                                victim = lru[r_idx];
  end

  assign fill_last = (st == S_FILL) && mem_ack && (cnt == LAST);

  assign cpu_ready = (st == S_IDLE);
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st == S_FILL) || (st == S_MRD) || (st == S_MWR);
  assign mem_write = (st == S_MWR);
  assign mem_addr  = (st == S_FILL) ? {r_tag, r_idx, cnt} : r_addr;
  assign mem_wdata = r_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      r_we     <= 1'b0;
      r_c      <= 1'b0;
      r_addr   <= '0;
      r_wdata  <= '0;
      rdata_q  <= '0;
      cnt      <= '0;
      fill_way <= 1'b0;
      done_q   <= 1'b0;
      vld[0]   <= '0;
      vld[1]   <= '0;
      lru      <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cpu_valid) begin
          r_we    <= cpu_write;
          r_c     <= cpu_cacheable;
          r_addr  <= cpu_addr;
          r_wdata <= cpu_wdata;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (!r_c) begin
            st <= r_we ? S_MWR : S_MRD;
          end else if (r_we) begin
            if (hit) lru[r_idx] <= ~hit_way;
            st <= S_MWR;
          end else if (hit) begin
            done_q      <= 1'b1;
            rdata_q     <= dat[hit_way][r_idx][r_off];
            lru[r_idx]  <= ~hit_way;
            st          <= S_IDLE;
          end else begin
            fill_way <= victim;
            cnt      <= '0;
            st       <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          if (cnt == r_off) begin
            done_q  <= 1'b1;
            rdata_q <= mem_rdata;
          end
          if (cnt == LAST) begin
            vld[fill_way][r_idx] <= 1'b1;
            lru[r_idx]           <= ~fill_way;
            st                   <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_MRD: if (mem_ack) begin
          done_q  <= 1'b1;
          rdata_q <= mem_rdata;
          st      <= S_IDLE;
        end
        S_MWR: if (mem_ack) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((st == S_FILL) && mem_ack)
      dat[fill_way][r_idx][cnt] <= mem_rdata;
    if (fill_last)
      tags[fill_way][r_idx] <= r_tag;
    if ((st == S_LOOK) && r_c && r_we && hit)
      dat[hit_way][r_idx][r_off] <= r_wdata;
  end
endmodule

// File: rtl/rgc_cache_chk.sv
module rgc_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [2*SETS-1:0] vld_flat,
  input logic              hit0,
  input logic              hit1
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready |=> !cpu_ready);

  a_r7_store_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_write |=> $stable(vld_flat));

  a_r3_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_write && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r4_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit0, hit1}) <= 1);
endmodule

bind rgc_cache rgc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .mem_req(mem_req), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .vld_flat({vld[1], vld[0]}), .hit0(hit0), .hit1(hit1)
);

// File: tb/rgc_cache_tb.sv
module rgc_cache_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, cpu_cacheable = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_done, mem_req, mem_write;
  logic [DW-1:0] cpu_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  rgc_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(4), .WAYS(2), .LINE_WORDS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_cacheable(cpu_cacheable), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] mem [1024];
  logic [AW-1:0] rlog [8];
  int wt = 0, rd_n = 0, wr_n = 0, done_n = 0;
  logic [AW-1:0] last_wa = '0;
  logic [DW-1:0] last_wd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wt <= 0;
      for (int i = 0; i < 1024; i++) mem[i] <= 32'hC000_0000 | i;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wt == 1) begin
        wt <= 0;
        mem_ack <= 1'b1;
        if (mem_write) begin
          mem[mem_addr] <= mem_wdata;
          wr_n <= wr_n + 1;
          last_wa <= mem_addr;
          last_wd <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr];
          rlog[rd_n % 8] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end else begin
        wt <= wt + 1;
      end
    end
  end

  always @(posedge clk) if (cpu_done) done_n <= done_n + 1;

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  logic [DW-1:0] o_rdata;
  int o_lat, o_rds, o_wrs, o_dns, o_rd_at_done, o_r0;
  logic o_ready_at_done;

  task automatic run(input logic we, input logic c, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd);
    int r0, w0, d0;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    r0 = rd_n; w0 = wr_n; d0 = done_n;
    cpu_valid = 1'b1; cpu_write = we; cpu_cacheable = c; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    o_lat = 0;
    while (!cpu_done && o_lat < 200) begin
      @(negedge clk);
      o_lat++;
    end
    o_rdata = cpu_rdata;
    o_rd_at_done = rd_n - r0;
    o_ready_at_done = cpu_ready;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    o_rds = rd_n - r0; o_wrs = wr_n - w0; o_dns = done_n - d0; o_r0 = r0;
  endtask

  typedef struct packed {
    logic        we;
    logic        c;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  nrd;
    logic [3:0]  nwr;
    logic [7:0]  rq;
  } vec_t;

  // set index = addr[3:2], offset = addr[1:0]
  localparam vec_t VEC [16] = '{
    '{1'b0, 1'b1, 10'h003, 32'h0,         32'hC000_0003, 4'd4, 4'd0, 8'd1},  // R1 R3
    '{1'b0, 1'b1, 10'h001, 32'h0,         32'hC000_0001, 4'd0, 4'd0, 8'd2},  // R2
    '{1'b0, 1'b1, 10'h012, 32'h0,         32'hC000_0012, 4'd4, 4'd0, 8'd4},  // R4
    '{1'b0, 1'b1, 10'h000, 32'h0,         32'hC000_0000, 4'd0, 4'd0, 8'd4},  // R4
    '{1'b0, 1'b1, 10'h020, 32'h0,         32'hC000_0020, 4'd4, 4'd0, 8'd5},  // R5
    '{1'b0, 1'b1, 10'h002, 32'h0,         32'hC000_0002, 4'd0, 4'd0, 8'd5},  // R5
    '{1'b0, 1'b1, 10'h011, 32'h0,         32'hC000_0011, 4'd4, 4'd0, 8'd5},  // R5
    '{1'b1, 1'b1, 10'h001, 32'h5555_0001, 32'h0,         4'd0, 4'd1, 8'd6},  // R6
    '{1'b0, 1'b1, 10'h001, 32'h0,         32'h5555_0001, 4'd0, 4'd0, 8'd6},  // R6
    '{1'b0, 1'b0, 10'h001, 32'h0,         32'h5555_0001, 4'd1, 4'd0, 8'd8},  // R8
    '{1'b1, 1'b1, 10'h045, 32'h6666_0045, 32'h0,         4'd0, 4'd1, 8'd7},  // R7
    '{1'b0, 1'b1, 10'h045, 32'h0,         32'h6666_0045, 4'd4, 4'd0, 8'd7},  // R7
    '{1'b1, 1'b0, 10'h046, 32'h7777_0046, 32'h0,         4'd0, 4'd1, 8'd9},  // R9
    '{1'b0, 1'b1, 10'h046, 32'h0,         32'hC000_0046, 4'd0, 4'd0, 8'd9},  // R9
    '{1'b0, 1'b0, 10'h046, 32'h0,         32'h7777_0046, 4'd1, 4'd0, 8'd8},  // R8
    '{1'b0, 1'b1, 10'h046, 32'h0,         32'hC000_0046, 4'd0, 4'd0, 8'd8}   // R8
  };

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b1, "R1", "ready in reset", 32'(cpu_ready), 1);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 0);
    chk(cpu_done == 1'b0, "R1", "done in reset", 32'(cpu_done), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      vec_t v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v.rq);
      run(v.we, v.c, v.addr, v.wdata);
      if (!v.we) chk(o_rdata == v.exp, rq, $sformatf("vec %0d rdata", i), o_rdata, v.exp);
      chk(o_rds == int'(v.nrd), rq, $sformatf("vec %0d reads", i), o_rds, 32'(v.nrd));
      chk(o_wrs == int'(v.nwr), rq, $sformatf("vec %0d writes", i), o_wrs, 32'(v.nwr));
      chk(o_dns == 1, "R11", $sformatf("vec %0d done pulses", i), o_dns, 1);
      if (v.we) begin
        chk(last_wa == v.addr, rq, $sformatf("vec %0d write addr", i), 32'(last_wa), 32'(v.addr));
        chk(last_wd == v.wdata, rq, $sformatf("vec %0d write data", i), last_wd, v.wdata);
      end
      if (!v.we && v.c && v.nrd == 4'd0)
        chk(o_lat == 1, "R2", $sformatf("vec %0d hit latency", i), o_lat, 1);
      if (v.nrd == 4'd4)
        for (int k = 0; k < 4; k++)
          chk(rlog[(o_r0 + k) % 8] == ((v.addr & ~10'h3) + AW'(k)), "R3",
              $sformatf("vec %0d fill beat %0d addr", i, k),
              32'(rlog[(o_r0 + k) % 8]), 32'((v.addr & ~10'h3) + AW'(k)));
    end

    // R3 R10: critical word in the middle of the line
    run(1'b0, 1'b1, 10'h081, 32'h0);
    chk(o_rdata == 32'hC000_0081, "R3", "critical word data", o_rdata, 32'hC000_0081);
    chk(o_rd_at_done == 2, "R3", "reads at done", o_rd_at_done, 2);
    chk(o_ready_at_done == 1'b0, "R10", "busy after critical word", 32'(o_ready_at_done), 0);
    chk(o_rds == 4, "R3", "full line reads", o_rds, 4);

    // R1: reset in the middle of the run invalidates everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cpu_ready == 1'b1, "R1", "ready in second reset", 32'(cpu_ready), 1);
    chk(mem_req == 1'b0, "R1", "mem_req in second reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    run(1'b0, 1'b1, 10'h002, 32'h0);
    chk(o_rds == 4, "R1", "miss after reset", o_rds, 4);
    chk(o_rdata == 32'hC000_0002, "R1", "data after reset", o_rdata, 32'hC000_0002);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule